// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Front End

This block is the digital register path of a two-channel voltage-output converter. A host places a parallel code on the data bus and pulls an active-low chip select. A channel-select bit steers the write into the input register of channel A or channel B. Each channel has a second register that holds the code its converter actually uses. An active-low, level-sensitive load strobe per channel moves the input register into that second register. Tying both strobes together updates both channels in one cycle after they were loaded one at a time. Holding a strobe low makes that channel single-buffered, so a write reaches its output straight away.

An active-low clear acts at once, without a clock, and sets both stages of both channels to zero. An active-low shutdown turns off the two output-enable flags and leaves every register operation working. All pins arrive asynchronously. The block samples them through synchronizer stages on the system clock, and the data bus goes through a matching register pipeline so that it stays aligned with its controls.

Top module: `dual_dac_regif`

## Requirements
- R1: The code width is the parameter W (default 12, 10 for the reduced variant); bit W-1 of `din` is the MSB and lands in bit W-1 of each code output.
- R2: Every pin value present at rising clock edge k acts on the registers at edge k+2 (two sampling stages, then the register update).
- R3: While sampled `cs_n` is 0, the input register of the channel chosen by `sel_a` (1 = channel A, 0 = channel B) takes `din`. The other input register does not change. While `cs_n` is 1, both input registers hold.
- R4: While a channel's sampled load strobe is 0, its code output follows its input register, including a value written on the same edge. While the strobe is 1, the code output holds.
- R5: With a channel's strobe held at 0, a write to that channel shows up on its code output on the same edge that the input register takes it.
- R6: Writes made with both strobes at 1 leave both code outputs unchanged. One joint strobe pulse then updates both outputs on the same edge.
- R7: `rst_n` at 0 clears both input registers and both code outputs to zero at once, with no clock edge needed. They stay zero after release until new writes and loads occur.
- R8: Reset wins over any write or load. Pin activity while `rst_n` is 0 is lost, and the internal clear is released on the second clock edge after `rst_n` rises.
- R9: While sampled `shdn_n` is 0, `oe_a` and `oe_b` are 0, and writes and loads proceed as usual. When `shdn_n` returns to 1, both flags go to 1 and the outputs carry the latest codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low clear of all registers |
| cs_n | input | 1 | Active-low chip select; write window |
| sel_a | input | 1 | Channel select: 1 = A, 0 = B |
| ld_a_n | input | 1 | Active-low level load strobe, channel A |
| ld_b_n | input | 1 | Active-low level load strobe, channel B |
| shdn_n | input | 1 | Active-low shutdown of both outputs |
| din | input | W | Parallel data bus |
| code_a | output | W | Channel A converter code |
| code_b | output | W | Channel B converter code |
| oe_a | output | 1 | Channel A output enable |
| oe_b | output | 1 | Channel B output enable |

## Verification
The bench checks that writes made with the strobes high leave both codes unchanged, then checks that one joint pulse updates both channels together. A design that loaded the second stage on write would fail the first check, and one with crossed strobes would split the update. A flow-through write with the strobe held low must appear on the next edge, and the unselected channel must keep its input register. A wrong channel decode shows up as a corrupted B code when B is loaded later. A clear in the middle of a write is checked before any clock edge and again after a later load, which shows up a synchronous clear or a write that survives the reset. A load made during shutdown must reach the code while both enables stay low, which shows up a shutdown that blocks writes.

// File: rtl/dacif_pkg.sv
`timescale 1ns/1ps
package dacif_pkg;
   localparam int NUM_CH = 2;
   typedef enum logic {
      CH_B = 1'b0,
      CH_A = 1'b1
   } chan_e;
endpackage

// File: rtl/dacif_sync.sv
`timescale 1ns/1ps
// Multi-stage sampler for asynchronous pins, reset to a chosen idle value.
module dacif_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dacif_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[s] <= RST_VAL;
            end else if (s == 0) begin
               stage_q[s] <= d;
            end else begin
               stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dacif_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of the internal clear.
module dacif_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n_o
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/dacif_chan.sv
`timescale 1ns/1ps
// One channel: address-decoded input register feeding a transparent code register.
module dacif_chan
   import dacif_pkg::*;
#(
   parameter int    W  = 12,
   parameter chan_e CH = CH_A
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cs_n_s,
   input  logic         sel_s,
   input  logic         ld_n_s,
   input  logic [W-1:0] data_s,
   output logic [W-1:0] code
);
   logic         hit;
   logic [W-1:0] in_q, in_nxt, code_q;

   assign hit    = !cs_n_s && (sel_s == logic'(CH));
   assign in_nxt = hit ? data_s : in_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q   <= '0;
         code_q <= '0;
      end else begin
         in_q <= in_nxt;
         if (!ld_n_s) code_q <= in_nxt;
      end
   end

   assign code = code_q;

   AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_s || (sel_s != logic'(CH))) |=> $stable(in_q)); // R3
   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_n_s |=> $stable(code)); // R4
   AST_CODE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_n_s |=> (code == in_q)); // R4
   AST_FLOW_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_n_s && !cs_n_s && (sel_s == logic'(CH))) |=> (code == $past(data_s))); // R5
endmodule

// File: rtl/dual_dac_regif.sv
`timescale 1ns/1ps
module dual_dac_regif
   import dacif_pkg::*;
#(
   parameter int W      = 12,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cs_n,
   input  logic         sel_a,
   input  logic         ld_a_n,
   input  logic         ld_b_n,
   input  logic         shdn_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] code_a,
   output logic [W-1:0] code_b,
   output logic         oe_a,
   output logic         oe_b
);
   localparam int          CTL_W   = 3 + NUM_CH;
   // idle: cs_n=1, sel=0, strobes=1, shdn_n=0 (outputs off until sampled)
   localparam logic [CTL_W-1:0] CTL_IDLE = {1'b1, 1'b0, {NUM_CH{1'b1}}, 1'b0};

   generate
      if (W < 2 || W > 16) begin : g_bad_width
         $error("dual_dac_regif: W out of range 2..16");
      end
   endgenerate

   logic                rst_int_n;
   logic [CTL_W-1:0]    ctl_raw, ctl_s;
   logic [W-1:0]        data_s;
   logic                cs_n_s, sel_s, shdn_s;
   logic [NUM_CH-1:0]   ld_n_s;
   logic [W-1:0]        code_arr [NUM_CH];
   logic                oe_q;

   dacif_rst_sync #(.STAGES(STAGES)) u_rst (
      .clk(clk), .arst_n(rst_n), .rst_n_o(rst_int_n));

   assign ctl_raw = {cs_n, sel_a, ld_a_n, ld_b_n, shdn_n};

   dacif_sync #(.W(CTL_W), .STAGES(STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
      .clk(clk), .rst_n(rst_int_n), .d(ctl_raw), .q(ctl_s));

   dacif_sync #(.W(W), .STAGES(STAGES), .RST_VAL('0)) u_data_pipe (
      .clk(clk), .rst_n(rst_int_n), .d(din), .q(data_s));

   assign cs_n_s = ctl_s[CTL_W-1];
   assign sel_s  = ctl_s[CTL_W-2];
   assign ld_n_s = ctl_s[NUM_CH:1];   // bit 1 = channel A (CH_A), bit 0 = channel B
   assign shdn_s = ctl_s[0];

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         dacif_chan #(.W(W), .CH(chan_e'(c))) u_chan (
            .clk(clk), .rst_n(rst_int_n), .cs_n_s(cs_n_s), .sel_s(sel_s),
            .ld_n_s(ld_n_s[c]), .data_s(data_s), .code(code_arr[c]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) oe_q <= 1'b0;
      else            oe_q <= shdn_s;
   end

   assign code_a = code_arr[CH_A];
   assign code_b = code_arr[CH_B];
   assign oe_a   = oe_q;
   assign oe_b   = oe_q;

   AST_SHDN_OFF: assert property (@(posedge clk) disable iff (!rst_int_n)
      !shdn_s |=> (!oe_a && !oe_b)); // R9
   AST_SHDN_KEEPS_LOAD: assert property (@(posedge clk) disable iff (!rst_int_n)
      (!shdn_s && !ld_n_s[CH_A] && !cs_n_s && sel_s) |=> (code_a == $past(data_s))); // R9
   AST_CLEAR_ZERO: assert property (@(posedge clk)
      !rst_int_n |-> (code_a == '0 && code_b == '0)); // R7
endmodule

// File: tb/dual_dac_regif_tb.sv
`timescale 1ns/1ps
module dual_dac_regif_tb;
   localparam int W = 12;

   logic clk = 1'b0;
   logic rst_n, cs_n, sel_a, ld_a_n, ld_b_n, shdn_n;
   logic [W-1:0] din;
   logic [W-1:0] code_a, code_b;
   logic oe_a, oe_b;

   int n_chk = 0, n_fail = 0;
   bit cmp_en = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dual_dac_regif #(.W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sel_a(sel_a),
      .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .shdn_n(shdn_n), .din(din),
      .code_a(code_a), .code_b(code_b), .oe_a(oe_a), .oe_b(oe_b));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- reference model from the requirements (R2..R9)
   typedef struct packed {
      logic cs; logic sel; logic la; logic lb; logic sd; logic [W-1:0] d;
   } pins_t;
   localparam pins_t IDLE_P = '{cs:1'b1, sel:1'b0, la:1'b1, lb:1'b1, sd:1'b0, d:'0};
   pins_t p1, p2;
   logic [W-1:0] m_in_a, m_in_b, m_cd_a, m_cd_b;
   logic m_oe;

   function automatic logic [W-1:0] next_in(input pins_t p, input logic ch, input logic [W-1:0] cur);
      return (!p.cs && p.sel == ch) ? p.d : cur;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p1 <= IDLE_P; p2 <= IDLE_P;
         m_in_a <= '0; m_in_b <= '0; m_cd_a <= '0; m_cd_b <= '0; m_oe <= 1'b0;
      end else begin
         p1 <= '{cs:cs_n, sel:sel_a, la:ld_a_n, lb:ld_b_n, sd:shdn_n, d:din};
         p2 <= p1;
         m_in_a <= next_in(p2, 1'b1, m_in_a);
         m_in_b <= next_in(p2, 1'b0, m_in_b);
         if (!p2.la) m_cd_a <= next_in(p2, 1'b1, m_in_a);
         if (!p2.lb) m_cd_b <= next_in(p2, 1'b0, m_in_b);
         m_oe <= p2.sd;
      end
   end

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         chk(code_a == m_cd_a, "R4 model code_a", 32'(code_a), 32'(m_cd_a));
         chk(code_b == m_cd_b, "R4 model code_b", 32'(code_b), 32'(m_cd_b));
         chk(oe_a == m_oe && oe_b == m_oe, "R9 model oe", {oe_a, oe_b}, {m_oe, m_oe});
      end
   end

   task automatic drv(input logic cs, input logic sel, input logic la, input logic lb,
                      input logic sd, input logic [W-1:0] d);
      @(negedge clk); #1;
      cs_n = cs; sel_a = sel; ld_a_n = la; ld_b_n = lb; shdn_n = sd; din = d;
   endtask

   task automatic idle(input logic sd);
      drv(1'b1, 1'b0, 1'b1, 1'b1, sd, '0);
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #1000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; cs_n = 1'b1; sel_a = 1'b0; ld_a_n = 1'b1; ld_b_n = 1'b1;
      shdn_n = 1'b1; din = '0;
      waitn(3);
      chk(code_a == 0 && code_b == 0, "R7 reset state codes", {code_a, code_b}, 0);
      chk(!oe_a && !oe_b, "R9 reset state oe", {oe_a, oe_b}, 0);
      chk($bits(code_a) == 12, "R1 code width", $bits(code_a), 12);
      @(negedge clk); #1 rst_n = 1'b1;
      waitn(6);
      cmp_en = 1'b1;

      // R6: separate loads with strobes high, then one joint strobe
      drv(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 12'h5A5);
      drv(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 12'h3C3);
      idle(1'b1);
      waitn(4);
      chk(code_a == 0 && code_b == 0, "R6 no update before strobe", {code_a, code_b}, 0);
      drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '0);
      idle(1'b1);
      @(negedge clk);
      chk(code_a == 0, "R2 no change at edge k+1", code_a, 0);
      @(negedge clk);
      chk(code_a == 12'h5A5 && code_b == 12'h3C3, "R2 R6 joint update at edge k+2",
          {code_a, code_b}, {12'h5A5, 12'h3C3});

      // R5: flow-through with strobe A held low
      drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 12'hABC);
      drv(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 12'h000);
      waitn(4);
      chk(code_a == 12'hABC, "R5 flow-through code_a", code_a, 12'hABC);
      chk(code_b == 12'h3C3, "R3 unselected code_b", code_b, 12'h3C3);
      // R3: cs high with strobe low, bus change ignored
      drv(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 12'hFFF);
      waitn(4);
      chk(code_a == 12'hABC, "R3 cs high holds input register", code_a, 12'hABC);
      drv(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 12'h000);
      idle(1'b1);
      waitn(4);
      chk(code_b == 12'h3C3, "R3 B input register untouched by A write", code_b, 12'h3C3);

      // R1: MSB lands in top bit
      drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 12'h800);
      idle(1'b1);
      waitn(4);
      chk(code_a == 12'h800 && code_a[W-1], "R1 MSB position", code_a, 12'h800);

      // R7 R8: reset in the middle of a write with strobe B low
      drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 12'h111);
      cmp_en = 1'b0;
      @(negedge clk); #1 rst_n = 1'b0;
      #0.5;
      chk(code_a == 0 && code_b == 0, "R7 asynchronous clear", {code_a, code_b}, 0);
      waitn(3);
      #1 cs_n = 1'b1; ld_b_n = 1'b1; din = '0;
      waitn(1);
      #1 rst_n = 1'b1;
      waitn(6);
      chk(code_a == 0 && code_b == 0, "R7 zero after release", {code_a, code_b}, 0);
      cmp_en = 1'b1;
      drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '0);
      idle(1'b1);
      waitn(4);
      chk(code_a == 0 && code_b == 0, "R8 write during reset lost", {code_a, code_b}, 0);

      // R9: load while in shutdown
      idle(1'b0);
      waitn(4);
      chk(!oe_a && !oe_b, "R9 enables off in shutdown", {oe_a, oe_b}, 0);
      drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h777);
      idle(1'b0);
      waitn(4);
      chk(code_a == 12'h777 && !oe_a, "R9 load proceeds in shutdown", {oe_a, code_a}, 12'h777);
      idle(1'b1);
      waitn(4);
      chk(oe_a && oe_b && code_a == 12'h777, "R9 release presents latest code",
          {oe_a, oe_b, code_a}, {2'b11, 12'h777});

      // constrained random phase, checked cycle by cycle against the model
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] r;
         r = 4'($urandom);
         drv(($urandom % 3) == 0 ? 1'b0 : 1'b1, 1'($urandom),
             ($urandom % 4) == 0 ? 1'b0 : 1'b1, ($urandom % 4) == 0 ? 1'b0 : 1'b1,
             (r == 0) ? 1'b0 : 1'b1, W'($urandom));
      end
      idle(1'b1);
      waitn(4);
      finish_run();
   end
endmodule